// File: doc/BRIEF.md
# Two-Step Egress Timestamp Queue

This block collects egress timestamps for frames sent in two-step PTP mode and holds them until software can read them. Each time a two-step frame leaves a port, the transmit path offers one push carrying the egress port number, the nanosecond stamp and the frame's sequence id. The queue turns that push into two linked entries and stores both in the same cycle. The first is the transmit entry, which holds the nanoseconds. The second follows it directly and holds the id, split across the stamp field and the sub-nanosecond field.

Software reads the oldest entry through a small register port. A status word gives a valid flag, an overflow flag, a transmit-entry flag and the egress port of the head entry. Two further words give the stamp field and the sub-nanosecond field. Writing the advance bit in the status word removes the head entry. A level interrupt stays high while any entry is waiting. When the queue has no room for a whole pair, the pair is discarded and a sticky overflow flag is set. Software clears that flag with a write.

Top module: `twostep_ts_queue`

## Requirements
- R1: After reset the status word (address 0) reads zero, and `irq` is low.
- R2: After a push, the head entry has status bit 0 (valid) = 1 and bit 2 (transmit entry) = 1, and bits [23:16] hold the pushed port. Address 1 reads the nanosecond stamp and address 2 reads 0.
- R3: The entry that follows a transmit entry has bit 2 = 0 and the same port. Address 1 reads `id >> 8` and address 2 reads `id[7:0]`.
- R4: Writing address 0 with bit 3 (advance) set removes the head entry. Entries come out in push order, two per push, and an empty queue reads a zero status word.
- R5: A push that arrives when fewer than two slots are free is dropped whole: no part of it is stored, and the stored entries are unchanged.
- R6: A dropped push sets status bit 1 (overflow). The flag stays set until software writes address 0 with bit 4 set. If a drop and a clear happen in the same cycle, the flag stays set.
- R7: `irq` is high exactly when the queue holds at least one entry.
- R8: An advance write to an empty queue has no effect.
- R9: A push and an advance in the same cycle both take effect.
- R10: Writes to addresses 1 to 3, and writes to address 0 with bit 3 clear, leave the queue contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Offer one two-step frame's timestamp |
| push_port | input | PORT_W | Egress port of the frame |
| push_nsec | input | NSEC_W | Transmit nanoseconds |
| push_id | input | ID_W | Frame sequence id |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 stamp, 2 sub-ns) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | High while the queue is not empty |

## Verification
The bench builds the queue with DEPTH = 4, so two pushes fill it. This makes the full and drop paths easy to reach. It also reaches the case where one free slot remains after a single advance and the pair still has to be dropped whole. The port width of 7 bits and the id width of 16 bits let the id split give a non-zero upper part in the stamp field. The same settings also cover the case where a push and an advance land in the same cycle.

// File: rtl/tsq_pkg.sv
// Shared register addresses and status-bit positions for the two-step
// timestamp queue. Assumes a 2-bit address and a 32-bit data path.
package tsq_pkg;
    localparam logic [1:0] ADDR_STATUS = 2'd0;
    localparam logic [1:0] ADDR_STAMP  = 2'd1;
    localparam logic [1:0] ADDR_SUBNS  = 2'd2;

    localparam int BIT_VALID   = 0;
    localparam int BIT_OVF     = 1;
    localparam int BIT_TXENT   = 2;
    localparam int BIT_ADVANCE = 3;
    localparam int BIT_OVF_CLR = 4;
    localparam int PORT_LSB    = 16;

    localparam int SUBNS_W = 8;
endpackage

// File: rtl/tsq_entry_fmt.sv
// Builds the two linked queue entries for one push. The entry layout is
// {txflag, port, stamp, subns}. Assumes ID_W - 8 <= NSEC_W and ID_W > 8.
module tsq_entry_fmt #(
    parameter int PORT_W = 7,
    parameter int NSEC_W = 30,
    parameter int ID_W   = 16,
    localparam int ENT_W = 1 + PORT_W + NSEC_W + tsq_pkg::SUBNS_W
) (
    input  logic [PORT_W-1:0] port,
    input  logic [NSEC_W-1:0] nsec,
    input  logic [ID_W-1:0]   id,
    output logic [ENT_W-1:0]  ent_tx,
    output logic [ENT_W-1:0]  ent_id
);
    localparam int HI_W = ID_W - tsq_pkg::SUBNS_W;

    logic [NSEC_W-1:0] id_hi;

    // Zero-extend the upper id bits into the stamp field.
    always_comb begin
        id_hi = '0;
        id_hi[HI_W-1:0] = id[ID_W-1:tsq_pkg::SUBNS_W];
    end

    // Transmit entry carries nanoseconds; id entry carries the split id.
    always_comb begin
        ent_tx = {1'b1, port, nsec, {tsq_pkg::SUBNS_W{1'b0}}};
        ent_id = {1'b0, port, id_hi, id[tsq_pkg::SUBNS_W-1:0]};
    end
endmodule

// File: rtl/tsq_store.sv
// Circular entry store that accepts two entries per cycle and pops one.
// A pair is accepted only if two slots are free, judged on the count before
// any same-cycle pop. Assumes DEPTH is a power of two and at least 2.
module tsq_store #(
    parameter int ENT_W = 46,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push2,
    input  logic [ENT_W-1:0] din0,
    input  logic [ENT_W-1:0] din1,
    input  logic             pop,
    output logic [ENT_W-1:0] head,
    output logic             not_empty,
    output logic [CNT_W-1:0] count,
    output logic             accept,
    output logic             drop,
    output logic             pop_eff
);
    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr_n1;

    // Decide whether this cycle's pair fits and whether a pop is real.
    always_comb begin
        accept    = push2 && (count <= CNT_W'(DEPTH - 2));
        drop      = push2 && !accept;
        not_empty = (count != '0);
        pop_eff   = pop && not_empty;
        wr_ptr_n1 = wr_ptr + PTR_W'(1);
        head      = mem[rd_ptr];
    end

    // Write both entries of an accepted pair into consecutive slots.
    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr]    <= din0;
            mem[wr_ptr_n1] <= din1;
        end
    end

    // Advance the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept)
                wr_ptr <= wr_ptr + PTR_W'(2);
            if (pop_eff)
                rd_ptr <= rd_ptr + PTR_W'(1);
            count <= count + (accept ? CNT_W'(2) : CNT_W'(0))
                           - (pop_eff ? CNT_W'(1) : CNT_W'(0));
        end
    end
endmodule

// File: rtl/tsq_regs.sv
// Register front end: decodes software writes into advance and overflow
// clear, holds the sticky overflow flag, and muxes the head entry onto the
// read bus. Assumes PORT_W <= 8 and NSEC_W <= 32.
module tsq_regs #(
    parameter int PORT_W = 7,
    parameter int NSEC_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              head_valid,
    input  logic              head_tx,
    input  logic [PORT_W-1:0] head_port,
    input  logic [NSEC_W-1:0] head_stamp,
    input  logic [7:0]        head_subns,
    input  logic              drop,
    output logic              pop,
    output logic              ovf,
    output logic              ovf_clr,
    output logic [31:0]       reg_rdata
);
    import tsq_pkg::*;

    logic status_wr;

    // Decode the status-word command bits.
    always_comb begin
        status_wr = reg_wr && (reg_addr == ADDR_STATUS);
        pop       = status_wr && reg_wdata[BIT_ADVANCE];
        ovf_clr   = status_wr && reg_wdata[BIT_OVF_CLR];
    end

    // Sticky overflow: a drop wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (drop)
            ovf <= 1'b1;
        else if (ovf_clr)
            ovf <= 1'b0;
    end

    // Read mux; head fields read as zero when the queue is empty.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_STATUS: begin
                reg_rdata[BIT_VALID] = head_valid;
                reg_rdata[BIT_OVF]   = ovf;
                reg_rdata[BIT_TXENT] = head_valid && head_tx;
                if (head_valid)
                    reg_rdata[PORT_LSB +: PORT_W] = head_port;
            end
            ADDR_STAMP:
                if (head_valid) reg_rdata[NSEC_W-1:0] = head_stamp;
            ADDR_SUBNS:
                if (head_valid) reg_rdata[7:0] = head_subns;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/twostep_ts_queue.sv
// Top of the two-step egress timestamp queue. Each push becomes a transmit
// entry followed by an id entry. Software reads and pops through three
// registers, and irq follows the not-empty state.
module twostep_ts_queue #(
    parameter int DEPTH  = 16,
    parameter int PORT_W = 7,
    parameter int NSEC_W = 30,
    parameter int ID_W   = 16,
    localparam int ENT_W = 1 + PORT_W + NSEC_W + tsq_pkg::SUBNS_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [PORT_W-1:0] push_port,
    input  logic [NSEC_W-1:0] push_nsec,
    input  logic [ID_W-1:0]   push_id,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    logic [ENT_W-1:0] ent_tx, ent_id, head;
    logic             not_empty, accept, drop, pop, pop_eff, ovf, ovf_clr;
    logic [CNT_W-1:0] count;

    tsq_entry_fmt #(.PORT_W(PORT_W), .NSEC_W(NSEC_W), .ID_W(ID_W)) u_fmt (
        .port(push_port), .nsec(push_nsec), .id(push_id),
        .ent_tx(ent_tx), .ent_id(ent_id)
    );

    tsq_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push2(push_valid),
        .din0(ent_tx), .din1(ent_id), .pop(pop),
        .head(head), .not_empty(not_empty), .count(count),
        .accept(accept), .drop(drop), .pop_eff(pop_eff)
    );

    tsq_regs #(.PORT_W(PORT_W), .NSEC_W(NSEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .head_valid(not_empty),
        .head_tx(head[ENT_W-1]),
        .head_port(head[ENT_W-2 -: PORT_W]),
        .head_stamp(head[tsq_pkg::SUBNS_W +: NSEC_W]),
        .head_subns(head[tsq_pkg::SUBNS_W-1:0]),
        .drop(drop), .pop(pop), .ovf(ovf), .ovf_clr(ovf_clr),
        .reg_rdata(reg_rdata)
    );

    // Level interrupt while any entry waits.
    always_comb irq = not_empty;
endmodule

// File: rtl/tsq_checker.sv
// Temporal checks on the queue's occupancy, sticky flag and interrupt,
// attached to the top by bind.
module tsq_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic [CNT_W-1:0] count,
    input logic             accept,
    input logic             drop,
    input logic             pop_eff,
    input logic             pop,
    input logic             ovf,
    input logic             ovf_clr
);
    assert_accept_raises_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> irq);
    assert_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_drop_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !pop_eff) |=> $stable(count));
    assert_no_overflow_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovf);
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
    assert_empty_pop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && pop && !accept) |=> !irq);
    assert_push_and_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pop_eff) |=> (count == $past(count) + CNT_W'(1)));
endmodule

bind twostep_ts_queue tsq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .count(count), .accept(accept),
    .drop(drop), .pop_eff(pop_eff), .pop(pop), .ovf(ovf), .ovf_clr(ovf_clr)
);

// File: tb/twostep_ts_queue_test.sv
module twostep_ts_queue_test;
    localparam int DEPTH = 4, PORT_W = 7, NSEC_W = 30, ID_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic push_valid = 1'b0;
    logic [PORT_W-1:0] push_port = '0;
    logic [NSEC_W-1:0] push_nsec = '0;
    logic [ID_W-1:0]   push_id = '0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    twostep_ts_queue #(.DEPTH(DEPTH), .PORT_W(PORT_W), .NSEC_W(NSEC_W), .ID_W(ID_W)) uut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_port(push_port),
        .push_nsec(push_nsec), .push_id(push_id), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] st(input bit v, input bit o, input bit tx, input int port);
        return {8'h0, 8'(port), 13'h0, tx, o, v};
    endfunction

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic push(input int port, input int ns, input int id);
        @(negedge clk);
        push_valid = 1'b1; push_port = PORT_W'(port);
        push_nsec = NSEC_W'(ns); push_id = ID_W'(id);
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    // Check the head as a transmit entry, then as the following id entry.
    task automatic expect_tx(input string req, input bit o, input int port, input int ns);
        logic [31:0] d;
        rd(2'd0, d); chk({req, " status tx"}, d, st(1, o, 1, port));
        rd(2'd1, d); chk({req, " stamp tx"}, d, 32'(ns));
        rd(2'd2, d); chk({req, " subns tx"}, d, 32'd0);
    endtask

    task automatic expect_id(input string req, input bit o, input int port, input int id);
        logic [31:0] d;
        rd(2'd0, d); chk({req, " status id"}, d, st(1, o, 0, port));
        rd(2'd1, d); chk({req, " stamp id"}, d, 32'(id >> 8));
        rd(2'd2, d); chk({req, " subns id"}, d, 32'(id & 8'hff));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(2'd0, d); chk("R1 status", d, 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
    endtask

    task automatic t_pair;
        logic [31:0] d;
        push(5, 123456789, 16'h1234);
        expect_tx("R2", 0, 5, 123456789);
        chk("R7 irq high", 32'(irq), 32'd1);
        wr(2'd0, 32'h8);
        expect_id("R3", 0, 5, 16'h1234);
        wr(2'd0, 32'h8);
        rd(2'd0, d); chk("R4 empty", d, 32'd0);
        chk("R7 irq low", 32'(irq), 32'd0);
    endtask

    task automatic t_order;
        logic [31:0] d;
        push(1, 1000, 16'h0102);
        push(2, 2000, 16'hab07);
        expect_tx("R4 A", 0, 1, 1000); wr(2'd0, 32'h8);
        expect_id("R4 A", 0, 1, 16'h0102); wr(2'd0, 32'h8);
        expect_tx("R4 B", 0, 2, 2000); wr(2'd0, 32'h8);
        expect_id("R4 B", 0, 2, 16'hab07); wr(2'd0, 32'h8);
        rd(2'd0, d); chk("R4 drained", d, 32'd0);
    endtask

    task automatic t_empty_pop;
        logic [31:0] d;
        wr(2'd0, 32'h8);
        rd(2'd0, d); chk("R8 still empty", d, 32'd0);
        push(9, 77, 16'h00ff);
        expect_tx("R8 after", 0, 9, 77); wr(2'd0, 32'h8);
        expect_id("R8 after", 0, 9, 16'h00ff); wr(2'd0, 32'h8);
        rd(2'd0, d); chk("R8 drained", d, 32'd0);
    endtask

    task automatic t_full;
        logic [31:0] d;
        push(3, 300, 16'h0301);
        push(4, 400, 16'h0402);
        push(6, 600, 16'h0603);
        expect_tx("R5 kept", 1, 3, 300);
        wr(2'd0, 32'h8);
        push(7, 700, 16'h0704);
        expect_id("R5 kept", 1, 3, 16'h0301); wr(2'd0, 32'h8);
        expect_tx("R5 second", 1, 4, 400); wr(2'd0, 32'h8);
        expect_id("R5 second", 1, 4, 16'h0402); wr(2'd0, 32'h8);
        rd(2'd0, d); chk("R6 sticky when empty", d, st(0, 1, 0, 0));
        wr(2'd0, 32'h10);
        rd(2'd0, d); chk("R6 cleared", d, 32'd0);
    endtask

    task automatic t_same_cycle;
        logic [31:0] d;
        push(10, 1111, 16'h2021);
        @(negedge clk);
        push_valid = 1'b1; push_port = 7'd11; push_nsec = 30'd2222; push_id = 16'h3031;
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h8;
        @(negedge clk);
        push_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        expect_id("R9 X", 0, 10, 16'h2021); wr(2'd0, 32'h8);
        expect_tx("R9 Y", 0, 11, 2222); wr(2'd0, 32'h8);
        expect_id("R9 Y", 0, 11, 16'h3031); wr(2'd0, 32'h8);
        rd(2'd0, d); chk("R9 drained", d, 32'd0);
    endtask

    task automatic t_ignored;
        logic [31:0] d;
        push(12, 5555, 16'h4142);
        wr(2'd1, 32'hffff_ffff);
        wr(2'd2, 32'hffff_ffff);
        wr(2'd3, 32'hffff_ffff);
        wr(2'd0, 32'hffff_fff7 & ~32'h10);
        expect_tx("R10 unchanged", 0, 12, 5555);
        wr(2'd0, 32'h8);
        expect_id("R10 unchanged", 0, 12, 16'h4142);
        wr(2'd0, 32'h8);
        rd(2'd0, d); chk("R10 drained", d, 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pair();
        t_order();
        t_empty_pop();
        t_full();
        t_same_cycle();
        t_ignored();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule